// File: doc/BRIEF.md
# Run-Length Debounce Filter

This block cleans up one noisy digital input for the logic after it. The raw level first passes through a two-stage synchronizer. The filtered output then changes only after the synchronized sample has disagreed with it on a fixed number of consecutive system clocks. Any clock on which the sample agrees with the output clears the run, so a burst of noise shorter than the chosen length never reaches the output. The same rule applies to rising and falling edges.

A three-bit mode word selects the behaviour. When its top bit is clear, the filter is bypassed and the output is the registered synchronized sample. When its top bit is set, the low two bits pick one of four run lengths. Sampling runs at the system clock rate, with no divider. The mode input is registered inside the block. On the clock where a new mode value is first seen, the run counter is cleared and the output holds its value.

Top module: `run_debounce`

## Requirements
- R1: While synchronous reset is asserted, and on the first clock after it is released, the output is 0 and the run counter is 0.
- R2: The raw input passes through exactly two register stages before any decision is made on it. In bypass, a change of the raw input is therefore not visible on the output after the second rising edge.
- R3: When mode bit 2 is 0 (modes 000 to 011), the output copies the synchronized sample. A level applied before rising edge k appears on the output at edge k+2, and a single-clock pulse passes through as a single-clock pulse.
- R4: When mode bit 2 is 1, mode bits 1:0 select the run length N: 00 gives 3, 01 gives 24, 10 gives 192 and 11 gives 1536 consecutive samples.
- R5: In filter mode, the run counter advances by one on each clock where the synchronized sample differs from the output and the terminal count N-1 has not yet been reached.
- R6: In filter mode, any clock where the sample equals the output clears the run counter. A differing run of N-1 samples or fewer never changes the output.
- R7: When the raw input takes a new level before rising edge k and holds it, the output takes that level at edge k+N+1 and not earlier.
- R8: The rule is symmetric: a falling run is filtered with the same N and the same timing as a rising run.
- R9: On the first rising edge at which the registered mode differs from the mode input, the counter clears and the output holds. Counting restarts on the following edge with the new run length.
- R10: The run counter never exceeds N-1. Once the output has changed, a continuing run does not change it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every sample is taken on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Asynchronous noisy input level |
| mode | input | 3 | Bit 2 selects filter (1) or bypass (0); bits 1:0 select the run length |
| clean_out | output | 1 | Debounced, synchronized level |

## Verification
Each result has a fixed latency counted from the rising edge that first captures a new raw level: the output follows at edge k+2 in bypass and at edge k+N+1 in filter mode. After a mode change, the output moves on the third edge after the change edge for N=3. The bench drives and samples on falling edges, so a wait of n falling edges covers exactly n rising edges. Each check is placed one edge before and one edge after the predicted change, which catches a result that arrives early as well as one that arrives late. Glitch runs of N-1 samples are monitored on every cycle until the synchronizer and the counter have settled.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

  // Run length chosen by the two select bits of the mode word.
  function automatic int unsigned run_target(input logic [1:0] sel,
                                             input int unsigned l0,
                                             input int unsigned l1,
                                             input int unsigned l2,
                                             input int unsigned l3);
    case (sel)
      2'd0:    return l0;
      2'd1:    return l1;
      2'd2:    return l2;
      default: return l3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c,
                                       input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width able to hold values 0 .. max_len-1.
  function automatic int unsigned cnt_width(input int unsigned max_len);
    return (max_len < 3) ? 1 : $clog2(max_len);
  endfunction

endpackage

// File: rtl/rdb_sync.sv
module rdb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rdb_mode_reg.sv
module rdb_mode_reg #(
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] mode_q,
  output logic              mode_chg
);
  // Under reset the register tracks the input, so that no change is seen at release.
  always_ff @(posedge clk) begin
    mode_q <= mode_in;
    if (rst) mode_q <= mode_in;
  end

  assign mode_chg = !rst && (mode_in != mode_q);
endmodule

// File: rtl/rdb_run_counter.sv
module rdb_run_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             differ,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt,
  output logic             flip
);
  logic at_term;

  assign at_term = (cnt == term);
  assign flip    = en && !clr && differ && at_term;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (clr || !en || !differ) cnt <= '0;
    else if (at_term)             cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/run_debounce.sv
module run_debounce #(
  parameter int unsigned LEN0        = 3,
  parameter int unsigned LEN1        = 24,
  parameter int unsigned LEN2        = 192,
  parameter int unsigned LEN3        = 1536,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_in,
  input  logic [2:0] mode,
  output logic       clean_out
);
  import rdb_pkg::*;

  localparam int unsigned MODE_W  = 3;
  localparam int unsigned MAX_LEN = max4(LEN0, LEN1, LEN2, LEN3);
  localparam int unsigned CNT_W   = cnt_width(MAX_LEN);

  // Named internal events, brought out for the checker.
  logic              samp_w;
  logic [MODE_W-1:0] mode_q_w;
  logic              mode_chg_w;
  logic              filt_en_w;
  logic              differ_w;
  logic [CNT_W-1:0]  term_w;
  logic [CNT_W-1:0]  run_cnt_w;
  logic              flip_w;
  logic              out_q;

  rdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (samp_w)
  );

  rdb_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_in  (mode),
    .mode_q   (mode_q_w),
    .mode_chg (mode_chg_w)
  );

  assign filt_en_w = mode_q_w[MODE_W-1];
  assign differ_w  = (samp_w != out_q);
  assign term_w    = CNT_W'(run_target(mode_q_w[1:0], LEN0, LEN1, LEN2, LEN3) - 1);

  rdb_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en     (filt_en_w),
    .clr    (mode_chg_w),
    .differ (differ_w),
    .term   (term_w),
    .cnt    (run_cnt_w),
    .flip   (flip_w)
  );

  always_ff @(posedge clk) begin
    if (rst)             out_q <= 1'b0;
    else if (mode_chg_w) out_q <= out_q;
    else if (!filt_en_w) out_q <= samp_w;
    else if (flip_w)     out_q <= ~out_q;
  end

  assign clean_out = out_q;
endmodule

// File: rtl/run_debounce_chk.sv
module run_debounce_chk #(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             samp,
  input logic             filt_en,
  input logic             mode_chg,
  input logic             differ,
  input logic [CNT_W-1:0] term,
  input logic [CNT_W-1:0] cnt,
  input logic             flip,
  input logic             out
);
  // R1: counter and output come out of reset cleared
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (cnt == '0) && !out);

  // R3: bypass copies the synchronized sample one edge later
  a_r3_bypass_copy: assert property (@(posedge clk) disable iff (rst)
    (!filt_en && !mode_chg) |=> (out == $past(samp)));

  // R5: the run advances on a differing sample below terminal count
  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (filt_en && !mode_chg && differ && !flip) |=> (cnt == $past(cnt) + 1'b1));

  // R6: an agreeing sample clears the run
  a_r6_clear_on_agree: assert property (@(posedge clk) disable iff (rst)
    (filt_en && !differ) |=> (cnt == '0));

  // R7: the output in filter mode moves only on a completed run
  a_r7_hold_until_run: assert property (@(posedge clk) disable iff (rst)
    (filt_en && !mode_chg && !flip) |=> $stable(out));

  // R7: a completed run takes the sampled level
  a_r7_flip_to_sample: assert property (@(posedge clk) disable iff (rst)
    flip |=> (out == $past(samp)));

  // R9: a mode change clears the run and holds the output
  a_r9_mode_change: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> ((cnt == '0) && $stable(out)));

  // R10: the counter stays within the selected run length
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    filt_en |-> (cnt <= term));
endmodule

bind run_debounce run_debounce_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .samp     (samp_w),
  .filt_en  (filt_en_w),
  .mode_chg (mode_chg_w),
  .differ   (differ_w),
  .term     (term_w),
  .cnt      (run_cnt_w),
  .flip     (flip_w),
  .out      (out_q)
);

// File: tb/run_debounce_test.sv
module run_debounce_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw_in = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       clean_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  run_debounce uut (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (raw_in),
    .mode      (mode),
    .clean_out (clean_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected under %0d", cycles, WATCHDOG);
      report();
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: clean_out actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Hold for n cycles and record one check: the output never leaves exp.
  task automatic watch_steady(input string req, input int n, input logic exp);
    logic bad = 1'b0;
    logic seen = exp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clean_out !== exp) begin bad = 1'b1; seen = clean_out; end
    end
    chk(req, bad ? seen : exp, exp);
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode = m;
    wait_n(4);
  endtask

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1; raw_in = 1'b0; mode = 3'b000;
    wait_n(4);
    chk("R1 during reset", clean_out, 1'b0);
    rst = 1'b0;
    wait_n(1);
    chk("R1 after release", clean_out, 1'b0);
  endtask

  // R2, R3: bypass latency and pulse pass-through
  task automatic t_bypass(input logic [2:0] m);
    set_mode(m);
    raw_in = 1'b1;
    wait_n(2);
    chk("R2 two sync stages, rise not yet out", clean_out, 1'b0);
    wait_n(1);
    chk("R3 bypass rise at edge k+2", clean_out, 1'b1);
    raw_in = 1'b0;
    wait_n(2);
    chk("R2 fall not yet out", clean_out, 1'b1);
    wait_n(1);
    chk("R3 bypass fall at edge k+2", clean_out, 1'b0);
    raw_in = 1'b1;
    wait_n(1);
    raw_in = 1'b0;
    wait_n(2);
    chk("R3 pulse rises", clean_out, 1'b1);
    wait_n(1);
    chk("R3 pulse one cycle wide", clean_out, 1'b0);
    wait_n(3);
  endtask

  // R4..R8, R10: one filter length, both directions
  task automatic t_filter(input logic [2:0] m, input int n, input string tag);
    set_mode(m);
    raw_in = 1'b0;
    wait_n(4);
    // R6: rising glitch of N-1 samples is rejected
    raw_in = 1'b1;
    wait_n(n - 1);
    raw_in = 1'b0;
    watch_steady({"R6 rising glitch rejected ", tag}, n + 4, 1'b0);
    // R5, R7, R4: held rise
    raw_in = 1'b1;
    wait_n(n + 1);
    chk({"R5 still counting one edge before run ends ", tag}, clean_out, 1'b0);
    wait_n(1);
    chk({"R7 R4 rise after full run ", tag}, clean_out, 1'b1);
    // R10: the continuing run changes nothing
    watch_steady({"R10 held high stays high ", tag}, n + 3, 1'b1);
    // R8: falling glitch rejected
    raw_in = 1'b0;
    wait_n(n - 1);
    raw_in = 1'b1;
    watch_steady({"R8 falling glitch rejected ", tag}, n + 4, 1'b1);
    // R8: held fall
    raw_in = 1'b0;
    wait_n(n + 1);
    chk({"R8 fall not before run ends ", tag}, clean_out, 1'b1);
    wait_n(1);
    chk({"R8 fall after full run ", tag}, clean_out, 1'b0);
    wait_n(3);
  endtask

  // R9: a mode change restarts the run with the new length
  task automatic t_mode_change();
    set_mode(3'b101);
    raw_in = 1'b0;
    wait_n(4);
    raw_in = 1'b1;
    wait_n(10);
    chk("R9 no rise after partial 24-run", clean_out, 1'b0);
    mode = 3'b100;
    wait_n(3);
    chk("R9 counter restarted on change", clean_out, 1'b0);
    wait_n(1);
    chk("R9 rise after fresh 3-run", clean_out, 1'b1);
    raw_in = 1'b0;
    wait_n(6);
  endtask

  initial begin
    t_reset();
    t_bypass(3'b000);
    t_bypass(3'b011);
    t_filter(3'b100, 3, "N=3");
    t_filter(3'b101, 24, "N=24");
    t_filter(3'b110, 192, "N=192");
    t_filter(3'b111, 1536, "N=1536");
    t_mode_change();
    done = 1'b1;
    report();
  end
endmodule